// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that acts as a small byte-wide serial EEPROM. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an open-drain enable, which pulls the line low when high. Three strap inputs give this target its place among up to eight identical targets on one bus.

After a START, the block collects an 8-bit control byte. The block answers only if the upper nibble is the fixed device code `1010` and the next three bits equal the straps. A write transfer carries a two-byte word address, high byte first, and the top three bits of that address are thrown away. Every later byte is stored at the address pointer, and the pointer then advances. A repeated START followed by a read control byte streams bytes from the pointer for as long as the master acknowledges. The 13-bit pointer wraps from `0x1FFF` to `0x0000`, so a transfer never runs into the range of another target.

The controller is a single state machine. Its states are:

- `ST_IDLE`: ignore the bus.
- `ST_CTRL`: shift in the control byte.
- `ST_CTRL_ACK`: acknowledge the control byte.
- `ST_ADDR_HI` and `ST_ADDR_HI_ACK`: take and acknowledge the high address byte.
- `ST_ADDR_LO` and `ST_ADDR_LO_ACK`: take and acknowledge the low address byte.
- `ST_WR_DATA` and `ST_WR_ACK`: take and acknowledge a data byte.
- `ST_RD_DATA`: drive a data byte.
- `ST_RD_ACK`: sample the master's acknowledge.

Its transitions are:

- A START moves any state to `ST_CTRL`, and a STOP moves any state to `ST_IDLE`.
- After the eighth control bit, the machine goes to `ST_CTRL_ACK` on a match and to `ST_IDLE` on a mismatch.
- `ST_CTRL_ACK` leads to `ST_RD_DATA` for a read and to `ST_ADDR_HI` for a write.
- The write path runs `ST_ADDR_HI` to `ST_ADDR_HI_ACK` to `ST_ADDR_LO` to `ST_ADDR_LO_ACK` to `ST_WR_DATA`, then loops between `ST_WR_DATA` and `ST_WR_ACK`.
- The read path goes from `ST_RD_DATA` to `ST_RD_ACK`. From there it returns to `ST_RD_DATA` on an ACK and goes to `ST_IDLE` on a NACK.

All bit-level moves happen on the synchronized falling edge of the bus clock. Received bits are sampled on the synchronized rising edge.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA pull-down enable is released (0) and the target ignores the bus until a START.
- R2: The target acknowledges a control byte only when its bits 7..4 are `1010` and its bits 3..1 equal `sel_i[2:0]`. On a mismatch it does not acknowledge, and it ignores every later byte until the next START.
- R3: After a write control byte (bit 0 = 0), two address bytes follow, high byte first and MSB first, and each is acknowledged. Bits 7..5 of the high byte are discarded, so only a 13-bit word address is kept.
- R4: Each data byte that follows the address bytes is acknowledged, written at the pointer, and followed by a pointer increment.
- R5: A read control byte (bit 0 = 1) makes the target drive bytes MSB first from the pointer, incrementing the pointer after each byte. A master ACK continues the read. After a master NACK the target keeps SDA released.
- R6: The 13-bit pointer wraps from `0x1FFF` to `0x0000` on both write and read increments.
- R7: A STOP (SDA rising while SCL is high) aborts any transfer, and a partly received data byte is not written. A START (SDA falling while SCL is high) at any point restarts control-byte reception.
- R8: The SDA enable changes only while the synchronized SCL is low. It is released right after an acknowledge bit and after the eighth driven data bit.
- R9: Write control, two address bytes, repeated START, then a read control byte returns the data stored at that address (a random read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_i | input | 3 | Strap levels that the control byte's select bits must match |
| sda_oe_o | output | 1 | Pull-down enable for SDA; 1 drives the line low |

## Verification
The assertions assume a well-formed master. It changes SDA only while SCL is low, except when it makes a START or STOP. It holds each SCL phase much longer than the synchronizer delay, so every edge reaches the state machine before the next one. The bench master keeps every SCL phase six system clocks long. It changes its data at the start of the low phase and samples in the middle of the high phase. It never tries a START or STOP while the target holds SDA low. Abort cases are made by stopping a byte after a few bits with SCL low and SDA under master control.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR_HI,
        ST_ADDR_HI_ACK,
        ST_ADDR_LO,
        ST_ADDR_LO_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } ee_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int WORD_AW     = 13,
    parameter int STORE_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    output logic       sda_oe_o
);

    localparam int         HI_BITS  = WORD_AW - 8;
    localparam logic [3:0] BITS_PER = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    ee_state_t          st, st_nx;
    logic [3:0]         bitcnt;
    logic [7:0]         shreg;
    logic [7:0]         rd_shift;
    logic [7:0]         rd_data;
    logic [WORD_AW-1:0] ptr;
    logic               mst_ack;
    logic               wr_en;
    logic               byte_end;
    logic               ctrl_match;
    logic               rx_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_store #(.AW(STORE_AW)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (ptr[STORE_AW-1:0]),
        .wr_data (shreg),
        .rd_addr (ptr[STORE_AW-1:0]),
        .rd_data (rd_data)
    );

    assign byte_end   = scl_fall && (bitcnt == BITS_PER);
    assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == sel_i);
    assign rx_state   = (st == ST_CTRL) || (st == ST_ADDR_HI) ||
                        (st == ST_ADDR_LO) || (st == ST_WR_DATA);

    // next-state decode
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = ST_CTRL;
        end else if (stop_det) begin
            st_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (st)
                ST_IDLE:        st_nx = ST_IDLE;
                ST_CTRL:        if (bitcnt == BITS_PER)
                                    st_nx = ctrl_match ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:    st_nx = shreg[0] ? ST_RD_DATA : ST_ADDR_HI;
                ST_ADDR_HI:     if (bitcnt == BITS_PER) st_nx = ST_ADDR_HI_ACK;
                ST_ADDR_HI_ACK: st_nx = ST_ADDR_LO;
                ST_ADDR_LO:     if (bitcnt == BITS_PER) st_nx = ST_ADDR_LO_ACK;
                ST_ADDR_LO_ACK: st_nx = ST_WR_DATA;
                ST_WR_DATA:     if (bitcnt == BITS_PER) st_nx = ST_WR_ACK;
                ST_WR_ACK:      st_nx = ST_WR_DATA;
                ST_RD_DATA:     if (bitcnt == BITS_PER) st_nx = ST_RD_ACK;
                ST_RD_ACK:      st_nx = mst_ack ? ST_RD_DATA : ST_IDLE;
                default:        st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rd_shift <= '0;
            ptr      <= '0;
            mst_ack  <= 1'b0;
        end else begin
            st <= st_nx;

            if (start_det || (scl_fall && st_nx != st)) begin
                bitcnt <= '0;
            end else if (scl_rise && bitcnt != BITS_PER &&
                         (rx_state || st == ST_RD_DATA)) begin
                bitcnt <= bitcnt + 4'd1;
            end

            if (scl_rise && rx_state) begin
                shreg <= {shreg[6:0], sda_s};
            end

            if (!start_det && !stop_det && byte_end) begin
                unique case (st)
                    ST_ADDR_HI: ptr[WORD_AW-1:8] <= shreg[HI_BITS-1:0];
                    ST_ADDR_LO: ptr[7:0]         <= shreg;
                    ST_WR_DATA,
                    ST_RD_DATA: ptr              <= ptr + 1'b1;
                    default:    ptr              <= ptr;
                endcase
            end

            if (st_nx == ST_RD_DATA && st != ST_RD_DATA) begin
                rd_shift <= rd_data;
            end else if (st == ST_RD_DATA && scl_fall && bitcnt != BITS_PER) begin
                rd_shift <= {rd_shift[6:0], 1'b0};
            end

            if (st == ST_RD_ACK && scl_rise) begin
                mst_ack <= ~sda_s;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        wr_en    = 1'b0;
        unique case (st)
            ST_CTRL_ACK,
            ST_ADDR_HI_ACK,
            ST_ADDR_LO_ACK,
            ST_WR_ACK:  sda_oe_o = 1'b1;
            ST_RD_DATA: sda_oe_o = ~rd_shift[7];
            ST_WR_DATA: wr_en    = byte_end && !start_det && !stop_det;
            default:    sda_oe_o = 1'b0;
        endcase
    end

    // R8: the pull-down enable moves only while the bus clock is low
    a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R2: the control acknowledge phase is reached only for a matching byte
    a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTRL_ACK) |-> (shreg[7:4] == DEV_CODE && shreg[3:1] == sel_i));

    // R4 / R6: a stored byte advances the pointer by one, wrapping at the top
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == WORD_AW'($past(ptr) + 1'b1)));

    // R7: a STOP always lands in idle
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    // R5: the master's acknowledge slot is never driven by the target
    a_r5_release_rd_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_ACK) |-> !sda_oe_o);

endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 6;
    localparam logic [2:0] SEL     = 3'b101;
    localparam logic [7:0] CTRL_WR = 8'hAA;
    localparam logic [7:0] CTRL_RD = 8'hAB;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl;
    logic       m_sda;
    logic       dut_oe;
    logic       sda_bus;
    logic       prev_oe;
    int         n_chk  = 0;
    int         n_fail = 0;
    int         oe_bad = 0;
    bit         done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~dut_oe;

    i2c_eeprom_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sel_i    (SEL),
        .sda_oe_o (dut_oe)
    );

    // R8 monitor: enable must not move while the master holds SCL high
    always @(negedge clk) begin
        if (rst_n && m_scl && dut_oe !== prev_oe) oe_bad++;
        prev_oe <= dut_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(PH);
        m_scl = 1'b1; wait_clk(PH);
        m_sda = 1'b0; wait_clk(PH);
        m_scl = 1'b0; wait_clk(PH);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(PH);
        m_scl = 1'b1; wait_clk(PH);
        m_sda = 1'b1; wait_clk(2*PH);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_clk(PH);
            m_scl = 1'b1; wait_clk(PH);
            m_scl = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        put_bits(b, 8);
        m_sda = 1'b1; wait_clk(PH);
        m_scl = 1'b1; wait_clk(PH/2);
        ack = ~sda_bus;
        wait_clk(PH - PH/2);
        m_scl = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, input logic ack);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wait_clk(PH);
            m_scl = 1'b1; wait_clk(PH/2);
            b = {b[6:0], sda_bus};
            wait_clk(PH - PH/2);
            m_scl = 1'b0;
        end
        m_sda = ~ack; wait_clk(PH);
        m_scl = 1'b1; wait_clk(PH);
        m_scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic wr_seq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic ak;
        bus_start();
        put_byte(CTRL_WR, ak);  chk("R2 control ack", 16'(ak), 16'd1);
        put_byte(a[15:8], ak);  chk("R3 high address ack", 16'(ak), 16'd1);
        put_byte(a[7:0], ak);   chk("R3 low address ack", 16'(ak), 16'd1);
        put_byte(d0, ak);       chk("R4 first data ack", 16'(ak), 16'd1);
        put_byte(d1, ak);       chk("R4 second data ack", 16'(ak), 16'd1);
        bus_stop();
    endtask

    task automatic rd_seq(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1);
        logic ak;
        bus_start();
        put_byte(CTRL_WR, ak);
        put_byte(a[15:8], ak);
        put_byte(a[7:0], ak);
        bus_start();
        put_byte(CTRL_RD, ak);  chk("R9 read control ack", 16'(ak), 16'd1);
        get_byte(r0, 1'b1);
        get_byte(r1, 1'b0);
        wait_clk(PH);
        chk("R5 released after NACK", 16'(dut_oe), 16'd0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 enable released after reset", 16'(dut_oe), 16'd0);
    endtask

    task automatic t_write_read();
        logic [7:0] r0, r1;
        wr_seq(16'h0123, 8'h5A, 8'hC3);
        rd_seq(16'h0123, r0, r1);
        chk("R5 first read byte", 16'(r0), 16'h005A);
        chk("R4 second byte at next address", 16'(r1), 16'h00C3);
    endtask

    task automatic t_mismatch();
        logic ak;
        logic [7:0] r0, r1;
        bus_start();
        put_byte(8'hBA, ak);  chk("R2 wrong device code NACK", 16'(ak), 16'd0);
        put_byte(8'h01, ak);  chk("R2 ignored after mismatch", 16'(ak), 16'd0);
        put_byte(8'h23, ak);
        put_byte(8'hFF, ak);
        bus_stop();
        bus_start();
        put_byte(8'hA4, ak);  chk("R2 wrong select bits NACK", 16'(ak), 16'd0);
        put_byte(8'h01, ak);
        put_byte(8'h23, ak);
        put_byte(8'hEE, ak);  chk("R2 data ignored after mismatch", 16'(ak), 16'd0);
        bus_stop();
        rd_seq(16'h0123, r0, r1);
        chk("R2 storage untouched by mismatch", 16'(r0), 16'h005A);
    endtask

    task automatic t_upper_dc();
        logic [7:0] r0, r1;
        wr_seq(16'hE140, 8'h77, 8'h78);
        rd_seq(16'h0140, r0, r1);
        chk("R3 upper address bits ignored", 16'(r0), 16'h0077);
    endtask

    task automatic t_wrap();
        logic [7:0] r0, r1;
        wr_seq(16'h1FFF, 8'h11, 8'h22);
        rd_seq(16'h0000, r0, r1);
        chk("R6 write wrapped to zero", 16'(r0), 16'h0022);
        rd_seq(16'h1FFF, r0, r1);
        chk("R6 read at top", 16'(r0), 16'h0011);
        chk("R6 read wrapped to zero", 16'(r1), 16'h0022);
    endtask

    task automatic t_abort();
        logic ak;
        logic [7:0] r0, r1;
        bus_start();
        put_byte(CTRL_WR, ak);
        put_byte(8'h01, ak);
        put_byte(8'h40, ak);
        put_bits(8'h00, 4);
        bus_stop();
        rd_seq(16'h0140, r0, r1);
        chk("R7 partial byte not written", 16'(r0), 16'h0077);
        bus_start();
        put_bits(CTRL_WR, 3);
        bus_start();
        put_byte(CTRL_WR, ak);  chk("R7 START restarts control byte", 16'(ak), 16'd1);
        bus_stop();
    endtask

    task automatic t_oe_rule();
        chk("R8 enable steady while SCL high", 16'(oe_bad), 16'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        m_scl   = 1'b1;
        m_sda   = 1'b1;
        prev_oe = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_read();
        t_mismatch();
        t_upper_dc();
        t_wrap();
        t_abort();
        t_oe_rule();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule